// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the host-visible programming register set of a four-channel DMA controller. Software talks to it over an 8-bit I/O bus using a 4-bit port offset, a write strobe and a read strobe. For every channel it keeps several values, and it presents all of them as output buses to the transfer engine. The first pair is a base and a current 16-bit address. The second pair is a base and a current 16-bit count. The count is loaded as one less than the number of transfers, so 0x0000 means one transfer and 0xFFFF means 65536. Each channel also has a 6-bit mode field and a mask bit.

Each 16-bit register sits behind a single byte port. One pointer flip-flop, shared by all channels, steps from the low byte to the high byte and back. Control ports cover several operations:
- the command byte
- software requests
- masking a single channel
- mode loading
- pointer reset
- master clear
- clearing all masks
- loading all masks
- status readback

The engine writes its advancing address and remaining count back through a per-channel update strobe. It reports terminal count on per-channel pulses.

A parameter can double the port spacing, so that a second copy decodes only even bus addresses.

Top module: `dma_regfile`

## Requirements
- R1: After reset the pointer selects the low byte. All four mask bits are 1. The command byte, software requests, terminal-count flags and every address, count and mode register are 0.
- R2: A 16-bit register is written as its low byte and then its high byte at the same port. Each write loads that byte into both the base and the current copy. The shared pointer flips on every read or write at offsets 0 to 7, and only on those accesses.
- R3: A write of any data to offset 0xC returns the pointer to the low-byte state.
- R4: Channel n (n = 0..3) has its address register at offset 2n and its count register at offset 2n+1.
- R5: A write to offset 0xA sets the mask of the channel given by data[1:0] to data[2]. A mask value of 1 disables the channel.
- R6: A write to offset 0xB stores data[7:2] as the 6-bit mode of the channel given by data[1:0]. Mode[1:0] is the direction (01 device to memory, 10 memory to device), mode[2] is auto-initialise, and mode[5:4] is the transfer type (01 single, 11 cascade).
- R7: A write to offset 0xD returns the pointer to low and clears the command byte, software requests and terminal-count flags. It sets all four masks to 1. Address, count and mode registers keep their values.
- R8: A write to offset 0xE clears all four masks. A write to offset 0xF loads the four masks from data[3:0], with bit n for channel n.
- R9: A read at offset 2n or 2n+1 returns the current address or current count of channel n, low byte or high byte according to the pointer. The read changes no register other than the pointer.
- R10: A read at offset 0x8 returns the terminal-count flags in bits 3:0 and the pending requests in bits 7:4. A request is pending when the request input or the software request is set. The read clears the flags, except that a terminal-count pulse in the same cycle leaves its flag set.
- R11: An engine update strobe for channel n loads that channel's current address and current count from the engine buses and leaves the base copies unchanged. A host write to one of those registers in the same cycle takes that byte from the host and keeps the other byte.
- R12: A write to offset 0x8 stores the command byte. A write to offset 0x9 sets the software request of the channel given by data[1:0] to data[2].
- R13: With STRIDE_SHIFT = 1 the port offset is taken from address bits 4:1, and accesses with address bit 0 set have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| eng_we | input | 4 | Per-channel engine update strobe |
| eng_addr | input | 16 | Engine current address value |
| eng_cnt | input | 16 | Engine remaining count value |
| eng_tc | input | 4 | Per-channel terminal-count pulse |
| dreq | input | 4 | Per-channel request lines |
| ch_base_addr | output | 64 | Base addresses, channel n at bits 16n+15:16n |
| ch_cur_addr | output | 64 | Current addresses |
| ch_base_cnt | output | 64 | Base counts |
| ch_cur_cnt | output | 64 | Current counts |
| ch_mode | output | 24 | Modes, channel n at bits 6n+5:6n |
| ch_mask | output | 4 | Mask bits |
| ch_swreq | output | 4 | Software request bits |
| cmd_reg | output | 8 | Command byte |

## Verification
The pointer flip-flop is the state that is easiest to corrupt without anyone noticing. If it is wrong, the next byte access lands in the wrong half of a register. That shows up on the register outputs one cycle after the write, or on io_rdata in the same cycle as the read. The bench therefore tracks the pointer in its own model and compares every register output after every access, including after master clear and pointer clear. A flag that is lost or cleared at the wrong time appears on the next status read. A mask, mode or request routed to the wrong channel appears on ch_mask, ch_mode or ch_swreq one cycle after the write.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
   localparam int NCH    = 4;
   localparam int BYTE_W = 8;
   localparam int RW     = 2 * BYTE_W;
   localparam int MODE_W = 6;
   localparam int OFS_W  = 4;

   localparam logic [OFS_W-1:0] PORT_CMD_STAT = 4'h8;
   localparam logic [OFS_W-1:0] PORT_SWREQ    = 4'h9;
   localparam logic [OFS_W-1:0] PORT_MASK1    = 4'hA;
   localparam logic [OFS_W-1:0] PORT_MODE     = 4'hB;
   localparam logic [OFS_W-1:0] PORT_PTRCLR   = 4'hC;
   localparam logic [OFS_W-1:0] PORT_MCLR     = 4'hD;
   localparam logic [OFS_W-1:0] PORT_MASKCLR  = 4'hE;
   localparam logic [OFS_W-1:0] PORT_MASKALL  = 4'hF;

   function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] v,
                                               input logic [BYTE_W-1:0] b,
                                               input logic hi);
      return hi ? {b, v[BYTE_W-1:0]} : {v[RW-1:BYTE_W], b};
   endfunction
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
   import dmareg_pkg::*;
#(
   parameter int STRIDE_SHIFT = 0,
   parameter int ADDR_W       = OFS_W + STRIDE_SHIFT
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [OFS_W-1:0]  ofs,
   output logic              wr_hit,
   output logic              rd_hit
);
   logic aligned;

   assign ofs = io_addr[STRIDE_SHIFT +: OFS_W];

   generate
      if (STRIDE_SHIFT == 0) begin : g_dense
         assign aligned = 1'b1;
      end else begin : g_even
         assign aligned = ~io_addr[0];
      end
   endgenerate

   assign wr_hit = io_wr & aligned;
   assign rd_hit = io_rd & aligned & ~io_wr;
endmodule

// File: rtl/dmareg_ptr.sv
module dmareg_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic hi
);
   always_ff @(posedge clk) begin
      if (!rst_n)     hi <= 1'b0;
      else if (clear) hi <= 1'b0;
      else if (step)  hi <= ~hi;
   end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
   import dmareg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              mode_we,
   input  logic              eng_we,
   input  logic [RW-1:0]     eng_addr,
   input  logic [RW-1:0]     eng_cnt,
   output logic [RW-1:0]     base_addr,
   output logic [RW-1:0]     cur_addr,
   output logic [RW-1:0]     base_cnt,
   output logic [RW-1:0]     cur_cnt,
   output logic [MODE_W-1:0] mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         cur_addr  <= '0;
         base_cnt  <= '0;
         cur_cnt   <= '0;
         mode      <= '0;
      end else begin
         if (wr_addr) begin
            base_addr <= put_byte(base_addr, wdata, ptr_hi);
            cur_addr  <= put_byte(cur_addr, wdata, ptr_hi);
         end else if (eng_we) begin
            cur_addr  <= eng_addr;
         end
         if (wr_cnt) begin
            base_cnt  <= put_byte(base_cnt, wdata, ptr_hi);
            cur_cnt   <= put_byte(cur_cnt, wdata, ptr_hi);
         end else if (eng_we) begin
            cur_cnt   <= eng_cnt;
         end
         if (mode_we) mode <= wdata[BYTE_W-1 -: MODE_W];
      end
   end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
   import dmareg_pkg::*;
#(
   parameter int STRIDE_SHIFT = 0,
   parameter int ADDR_W       = OFS_W + STRIDE_SHIFT
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic [BYTE_W-1:0]     io_wdata,
   input  logic                  io_wr,
   input  logic                  io_rd,
   output logic [BYTE_W-1:0]     io_rdata,
   input  logic [NCH-1:0]        eng_we,
   input  logic [RW-1:0]         eng_addr,
   input  logic [RW-1:0]         eng_cnt,
   input  logic [NCH-1:0]        eng_tc,
   input  logic [NCH-1:0]        dreq,
   output logic [NCH*RW-1:0]     ch_base_addr,
   output logic [NCH*RW-1:0]     ch_cur_addr,
   output logic [NCH*RW-1:0]     ch_base_cnt,
   output logic [NCH*RW-1:0]     ch_cur_cnt,
   output logic [NCH*MODE_W-1:0] ch_mode,
   output logic [NCH-1:0]        ch_mask,
   output logic [NCH-1:0]        ch_swreq,
   output logic [BYTE_W-1:0]     cmd_reg
);
   localparam int CH_W = $clog2(NCH);

   generate
      if (STRIDE_SHIFT != 0 && STRIDE_SHIFT != 1) begin : g_bad_stride
         $error("dma_regfile: STRIDE_SHIFT must be 0 or 1");
      end
      if (ADDR_W != OFS_W + STRIDE_SHIFT) begin : g_bad_aw
         $error("dma_regfile: ADDR_W must equal 4 + STRIDE_SHIFT");
      end
      if (2 * NCH > int'(PORT_CMD_STAT)) begin : g_bad_nch
         $error("dma_regfile: channel ports overlap control ports");
      end
   endgenerate

   logic [OFS_W-1:0] ofs;
   logic             wr_hit, rd_hit;
   logic             ptr_hi;
   logic             reg_acc, mclr, stat_rd;
   logic [NCH-1:0]   tc_q;
   logic [RW-1:0]    cur_a [NCH];
   logic [RW-1:0]    cur_c [NCH];
   logic [CH_W-1:0]  wsel;
   logic [RW-1:0]    rd16;

   dmareg_decode #(.STRIDE_SHIFT(STRIDE_SHIFT), .ADDR_W(ADDR_W)) u_dec (
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .ofs(ofs), .wr_hit(wr_hit), .rd_hit(rd_hit)
   );

   assign reg_acc = (wr_hit | rd_hit) & ~ofs[OFS_W-1];
   assign mclr    = wr_hit & (ofs == PORT_MCLR);
   assign stat_rd = rd_hit & (ofs == PORT_CMD_STAT);
   assign wsel    = io_wdata[CH_W-1:0];

   dmareg_ptr u_ptr (
      .clk(clk), .rst_n(rst_n),
      .clear(wr_hit & ((ofs == PORT_PTRCLR) | (ofs == PORT_MCLR))),
      .step(reg_acc), .hi(ptr_hi)
   );

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         dmareg_chan u_chan (
            .clk(clk), .rst_n(rst_n), .ptr_hi(ptr_hi), .wdata(io_wdata),
            .wr_addr(wr_hit & (ofs == OFS_W'(2 * g))),
            .wr_cnt(wr_hit & (ofs == OFS_W'(2 * g + 1))),
            .mode_we(wr_hit & (ofs == PORT_MODE) & (wsel == CH_W'(g))),
            .eng_we(eng_we[g]), .eng_addr(eng_addr), .eng_cnt(eng_cnt),
            .base_addr(ch_base_addr[g*RW +: RW]), .cur_addr(cur_a[g]),
            .base_cnt(ch_base_cnt[g*RW +: RW]), .cur_cnt(cur_c[g]),
            .mode(ch_mode[g*MODE_W +: MODE_W])
         );
         assign ch_cur_addr[g*RW +: RW] = cur_a[g];
         assign ch_cur_cnt[g*RW +: RW]  = cur_c[g];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch_mask  <= '1;
         ch_swreq <= '0;
         cmd_reg  <= '0;
         tc_q     <= '0;
      end else begin
         tc_q <= ((stat_rd | mclr) ? '0 : tc_q) | eng_tc;
         if (mclr) begin
            ch_mask  <= '1;
            ch_swreq <= '0;
            cmd_reg  <= '0;
         end else if (wr_hit) begin
            case (ofs)
               PORT_CMD_STAT: cmd_reg        <= io_wdata;
               PORT_SWREQ:    ch_swreq[wsel] <= io_wdata[2];
               PORT_MASK1:    ch_mask[wsel]  <= io_wdata[2];
               PORT_MASKCLR:  ch_mask        <= '0;
               PORT_MASKALL:  ch_mask        <= io_wdata[NCH-1:0];
               default: ;
            endcase
         end
      end
   end

   assign rd16 = ofs[0] ? cur_c[ofs[CH_W:1]] : cur_a[ofs[CH_W:1]];

   always_comb begin
      io_rdata = '0;
      if (rd_hit) begin
         if (!ofs[OFS_W-1])
            io_rdata = ptr_hi ? rd16[RW-1:BYTE_W] : rd16[BYTE_W-1:0];
         else if (ofs == PORT_CMD_STAT)
            io_rdata = {dreq | ch_swreq, tc_q};
      end
   end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
   import dmareg_pkg::*;
#(
   parameter int STRIDE_SHIFT = 0,
   parameter int ADDR_W       = OFS_W + STRIDE_SHIFT
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     io_addr,
   input logic [BYTE_W-1:0]     io_wdata,
   input logic                  io_wr,
   input logic                  io_rd,
   input logic [NCH*RW-1:0]     ch_base_addr,
   input logic [NCH*RW-1:0]     ch_base_cnt,
   input logic [NCH*MODE_W-1:0] ch_mode,
   input logic [NCH-1:0]        ch_mask,
   input logic                  ptr_hi,
   input logic [NCH-1:0]        tc_q
);
   logic [OFS_W-1:0] o;
   logic ok, w, r;
   assign o  = io_addr[STRIDE_SHIFT +: OFS_W];
   assign ok = (STRIDE_SHIFT == 0) || !io_addr[0];
   assign w  = io_wr && ok;
   assign r  = io_rd && ok && !io_wr;

   AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((w || r) && o < 4'h8) |=> (ptr_hi != $past(ptr_hi))); // R2
   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !w |=> ($stable(ch_base_addr) && $stable(ch_base_cnt))); // R2
   AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (w && o == PORT_PTRCLR) |=> !ptr_hi); // R3
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(w && o == PORT_MODE) |=> $stable(ch_mode)); // R6
   AST_MCLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (w && o == PORT_MCLR) |=> (ch_mask == 4'hF && !ptr_hi)); // R7
   AST_MASKCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (w && o == PORT_MASKCLR) |=> (ch_mask == 4'h0)); // R8
   AST_MASKALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (w && o == PORT_MASKALL) |=> (ch_mask == $past(io_wdata[3:0]))); // R8
   AST_TC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !((r && o == PORT_CMD_STAT) || (w && o == PORT_MCLR))
      |=> ((tc_q & $past(tc_q)) == $past(tc_q))); // R10
endmodule

bind dma_regfile dma_regfile_chk #(.STRIDE_SHIFT(STRIDE_SHIFT), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
   .io_wr(io_wr), .io_rd(io_rd), .ch_base_addr(ch_base_addr),
   .ch_base_cnt(ch_base_cnt), .ch_mode(ch_mode), .ch_mask(ch_mask),
   .ptr_hi(ptr_hi), .tc_q(tc_q)
);

// File: tb/dma_regfile_test.sv
`timescale 1ns/1ps
module dma_regfile_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [3:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic [3:0]  eng_we = '0, eng_tc = '0, dreq = '0;
   logic [15:0] eng_addr = '0, eng_cnt = '0;
   logic [63:0] ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt;
   logic [23:0] ch_mode;
   logic [3:0]  ch_mask, ch_swreq;
   logic [7:0]  cmd_reg;

   dma_regfile uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .eng_we(eng_we),
      .eng_addr(eng_addr), .eng_cnt(eng_cnt), .eng_tc(eng_tc), .dreq(dreq),
      .ch_base_addr(ch_base_addr), .ch_cur_addr(ch_cur_addr),
      .ch_base_cnt(ch_base_cnt), .ch_cur_cnt(ch_cur_cnt), .ch_mode(ch_mode),
      .ch_mask(ch_mask), .ch_swreq(ch_swreq), .cmd_reg(cmd_reg)
   );

   logic [4:0]  w_addr = '0;
   logic [7:0]  w_wdata = '0, w_rdata, w_cmd;
   logic        w_wr = 1'b0;
   logic [63:0] w_ba, w_ca, w_bc, w_cc;
   logic [23:0] w_mode;
   logic [3:0]  w_mask, w_sw;

   dma_regfile #(.STRIDE_SHIFT(1)) uut_wide (
      .clk(clk), .rst_n(rst_n), .io_addr(w_addr), .io_wdata(w_wdata),
      .io_wr(w_wr), .io_rd(1'b0), .io_rdata(w_rdata), .eng_we(4'h0),
      .eng_addr(16'h0), .eng_cnt(16'h0), .eng_tc(4'h0), .dreq(4'h0),
      .ch_base_addr(w_ba), .ch_cur_addr(w_ca), .ch_base_cnt(w_bc),
      .ch_cur_cnt(w_cc), .ch_mode(w_mode), .ch_mask(w_mask),
      .ch_swreq(w_sw), .cmd_reg(w_cmd)
   );

   int checks = 0, errors = 0;

   // reference model
   logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
   logic [5:0]  m_mode[4];
   logic [3:0]  m_mask, m_tc, m_sw;
   logic [7:0]  m_cmd;
   bit          m_ptr;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] put(input logic [15:0] v, input logic [7:0] d, input bit hi);
      return hi ? {d, v[7:0]} : {v[15:8], d};
   endfunction

   function automatic logic [63:0] pk(input logic [15:0] a[4]);
      return {a[3], a[2], a[1], a[0]};
   endfunction

   function automatic void m_reset();
      for (int i = 0; i < 4; i++) begin
         m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
      end
      m_mask = 4'hF; m_tc = 0; m_sw = 0; m_cmd = 0; m_ptr = 0;
   endfunction

   function automatic void m_write(input logic [3:0] o, input logic [7:0] d);
      int ch;
      ch = int'(o[2:1]);
      if (o < 8) begin
         if (o[0]) begin m_bc[ch] = put(m_bc[ch], d, m_ptr); m_cc[ch] = put(m_cc[ch], d, m_ptr); end
         else      begin m_ba[ch] = put(m_ba[ch], d, m_ptr); m_ca[ch] = put(m_ca[ch], d, m_ptr); end
         m_ptr = !m_ptr;
      end else begin
         case (o)
            4'h8: m_cmd = d;
            4'h9: m_sw[d[1:0]] = d[2];
            4'hA: m_mask[d[1:0]] = d[2];
            4'hB: m_mode[d[1:0]] = d[7:2];
            4'hC: m_ptr = 0;
            4'hD: begin m_ptr = 0; m_cmd = 0; m_sw = 0; m_tc = 0; m_mask = 4'hF; end
            4'hE: m_mask = 4'h0;
            default: m_mask = d[3:0];
         endcase
      end
   endfunction

   function automatic logic [7:0] m_read(input logic [3:0] o);
      logic [15:0] v;
      if (o < 8) begin
         v = o[0] ? m_cc[o[2:1]] : m_ca[o[2:1]];
         return m_ptr ? v[15:8] : v[7:0];
      end
      if (o == 4'h8) return {dreq | m_sw, m_tc};
      return 8'h00;
   endfunction

   function automatic void m_read_fx(input logic [3:0] o);
      if (o < 8) m_ptr = !m_ptr;
      if (o == 4'h8) m_tc = 0;
   endfunction

   task automatic host(input logic [3:0] o, input logic [7:0] d, input bit w,
                       input string tag, input logic [3:0] tcin = 4'h0);
      @(negedge clk);
      io_addr = o; io_wdata = d; io_wr = w; io_rd = !w; eng_tc = tcin;
      #1;
      if (!w) chk(tag, {56'h0, io_rdata}, {56'h0, m_read(o)});
      @(posedge clk); #1;
      io_wr = 0; io_rd = 0; eng_tc = 0;
      if (w) m_write(o, d); else m_read_fx(o);
      m_tc = m_tc | tcin;
   endtask

   task automatic eng(input int ch, input logic [15:0] a, input logic [15:0] c);
      @(negedge clk);
      eng_we = 4'(1 << ch); eng_addr = a; eng_cnt = c;
      @(posedge clk); #1;
      eng_we = 0;
      m_ca[ch] = a; m_cc[ch] = c;
   endtask

   task automatic tcpulse(input logic [3:0] t);
      @(negedge clk); eng_tc = t;
      @(posedge clk); #1; eng_tc = 0;
      m_tc = m_tc | t;
   endtask

   task automatic check_all(input string tag);
      logic [63:0] md;
      md = {40'h0, m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
      chk(tag, ch_base_addr, pk(m_ba));
      chk(tag, ch_cur_addr, pk(m_ca));
      chk(tag, ch_base_cnt, pk(m_bc));
      chk(tag, ch_cur_cnt, pk(m_cc));
      chk(tag, {40'h0, ch_mode}, md);
      chk(tag, {60'h0, ch_mask}, {60'h0, m_mask});
      chk(tag, {60'h0, ch_swreq}, {60'h0, m_sw});
      chk(tag, {56'h0, cmd_reg}, {56'h0, m_cmd});
   endtask

   task automatic whost(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); w_addr = a; w_wdata = d; w_wr = 1;
      @(posedge clk); #1; w_wr = 0;
   endtask

   initial begin
      #(8ns * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_reset();
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      check_all("R1 reset");
      host(4'h8, 8'h00, 0, "R1 status after reset");
      host(4'h0, 8'h11, 1, "R1");
      check_all("R1 pointer low after reset");

      // R4 and R2: channel 2 address at 4, count at 5
      host(4'hC, 8'h00, 1, "R3");
      host(4'h4, 8'h34, 1, "R4"); host(4'h4, 8'h12, 1, "R4");
      host(4'h5, 8'hFF, 1, "R2"); host(4'h5, 8'hFF, 1, "R2");
      check_all("R2 R4 byte pair load");

      // R9 readback, R11 engine update
      host(4'h5, 8'h00, 0, "R9 count low"); host(4'h5, 8'h00, 0, "R9 count high");
      eng(2, 16'hABCD, 16'h0102);
      check_all("R11 engine update");
      host(4'h4, 8'h00, 0, "R9 addr low"); host(4'h4, 8'h00, 0, "R9 addr high");
      host(4'h5, 8'h00, 0, "R9 cur count low"); host(4'h5, 8'h00, 0, "R9 cur count high");
      check_all("R9 reads change nothing");

      // R3 clear pointer mid-pair
      host(4'h0, 8'hAA, 1, "R3");
      host(4'hC, 8'h5A, 1, "R3");
      host(4'h0, 8'h55, 1, "R3");
      check_all("R3 pointer cleared");
      host(4'h0, 8'h66, 1, "R3");

      // R5 single mask
      host(4'hA, 8'h02, 1, "R5"); host(4'hA, 8'h01, 1, "R5");
      check_all("R5 unmask ch1 ch2");
      host(4'hA, 8'h05, 1, "R5");
      check_all("R5 remask ch1");

      // R6 mode
      host(4'hB, 8'h4B, 1, "R6"); host(4'hB, 8'hD6, 1, "R6");
      check_all("R6 mode fields");

      // R12 command and request
      host(4'h8, 8'hA5, 1, "R12"); host(4'h9, 8'h07, 1, "R12");
      check_all("R12 cmd and swreq");
      dreq = 4'h1;
      host(4'h8, 8'h00, 0, "R10 request bits");
      host(4'h9, 8'h03, 1, "R12"); check_all("R12 swreq clear");

      // R10 terminal count
      tcpulse(4'h5);
      host(4'h8, 8'h00, 0, "R10 tc flags");
      host(4'h8, 8'h00, 0, "R10 tc cleared by read");
      tcpulse(4'h2);
      host(4'h8, 8'h00, 0, "R10 read with pulse", 4'h8);
      host(4'h8, 8'h00, 0, "R10 same-cycle pulse kept");

      // R8 mask clear and mask all
      host(4'hE, 8'hFF, 1, "R8"); check_all("R8 clear masks");
      host(4'hF, 8'hFA, 1, "R8"); check_all("R8 load masks");

      // R7 master clear with pointer high and flags set
      host(4'h8, 8'h3C, 1, "R7"); tcpulse(4'h3);
      host(4'h1, 8'h77, 1, "R7");
      host(4'hD, 8'h00, 1, "R7");
      check_all("R7 master clear");
      host(4'h8, 8'h00, 0, "R7 flags cleared");
      host(4'h1, 8'h99, 1, "R7"); check_all("R7 pointer low after clear");
      dreq = 4'h0;

      // R11 host write beats engine in same cycle
      @(negedge clk);
      io_addr = 4'h6; io_wdata = 8'hE1; io_wr = 1; eng_we = 4'h8;
      eng_addr = 16'h4321; eng_cnt = 16'h0F0E;
      @(posedge clk); #1; io_wr = 0; eng_we = 0;
      m_write(4'h6, 8'hE1); m_cc[3] = 16'h0F0E;
      check_all("R11 host byte wins");

      // R13 wide decode instance
      #1 chk("R13 wide reset", {60'h0, w_mask}, 64'hF);
      whost(5'h14, 8'h00); #1 chk("R13 even mask port", {60'h0, w_mask}, 64'hE);
      whost(5'h15, 8'h01); #1 chk("R13 odd ignored", {60'h0, w_mask}, 64'hE);
      whost(5'h1C, 8'h00); #1 chk("R13 clear masks", {60'h0, w_mask}, 64'h0);
      whost(5'h1F, 8'h0F); #1 chk("R13 odd ignored", {60'h0, w_mask}, 64'h0);
      whost(5'h1E, 8'h05); #1 chk("R13 mask all", {60'h0, w_mask}, 64'h5);

      // constrained random mix
      for (int i = 0; i < 500; i++) begin
         int k;
         logic [3:0] o;
         k = int'($urandom % 12);
         o = 4'($urandom);
         dreq = 4'($urandom);
         if (k < 6) begin
            if (o == 4'hD && ($urandom % 4) != 0) o = 4'h0;
            host(o, 8'($urandom), 1, "R2 random write");
         end else if (k < 9) host(o, 8'h00, 0, "R9 random read");
         else if (k == 9) eng(int'($urandom % 4), 16'($urandom), 16'($urandom));
         else if (k == 10) tcpulse(4'($urandom));
         else host(4'h8, 8'h00, 0, "R10 random status", 4'($urandom));
         check_all("R2 random state");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule